// File: doc/BRIEF.md
# DMA Interrupt Status and Global Control Registers

This block holds the interrupt state and global control registers of a multi-channel DMA controller built with 2 or 8 channels. The channel engines stay outside it. Each engine pulses a terminal-count event or an error event, and presents its 32-bit configuration word as an input. The block latches each event into a raw status bit that stays set until software clears it. It takes the per-channel interrupt enables straight from the configuration words, so there is no separate mask register. It drives one interrupt line whenever an enabled status bit is set.

Software reaches the block through a simple single-cycle register request port. Each request gets a registered response one cycle later. The block offers these registers:
- masked views of the interrupt status;
- raw views of the interrupt status;
- write-one-to-clear ports;
- a read-only bitmap of enabled channels;
- a global configuration register that carries the controller enable;
- a register for request-line synchronisation settings;
- eight read-only identification words.

Requests that land in the per-channel window are decoded to a channel strobe and a word index. These are passed to the channel engines, and the engine's read word is returned on the response.

Top module: `dma_irq_regs`

## Requirements
- R1: For channel c, the terminal-count interrupt enable is bit 15 of that channel's configuration word, and the error interrupt enable is bit 14. Changing either bit changes the masked views and the interrupt line, with no event needed.
- R2: `irq_o` is high exactly when some channel has both its raw terminal-count bit and its terminal-count enable set, or both its raw error bit and its error enable set.
- R3: A pulse on `tc_evt_i[c]` or `err_evt_i[c]` sets the matching raw bit on the next clock edge. The bit stays set until it is cleared.
- R4: A write to offset 0x008 clears the raw terminal-count bits where the write data holds ones. A write to offset 0x010 does the same for the raw error bits. Bits written as zero keep their value. Reads of these two offsets return zero.
- R5: If an event and a clear write reach the same bit in the same cycle, the bit is set after that edge.
- R6: Reads return the following status views. Offset 0x000 returns the OR of the masked terminal-count and masked error bits. Offset 0x004 returns the masked terminal-count bits, and 0x00C the masked error bits. Offset 0x014 returns the raw terminal-count bits, and 0x018 the raw error bits. Bit c of each word belongs to channel c, and the upper bits read as zero.
- R7: Offset 0x01C reads a bitmap in which bit c is bit 0 (the channel enable) of channel c's configuration word.
- R8: Offset 0x030 is the global configuration register. Only bit 0, the controller enable, is stored; it drives `ctl_en_o`, and the other bits read as zero. Offset 0x034 holds the low SYNC_W bits of the written data, reads back zero-extended and drives `sync_o`.
- R9: The eight words at 0xFE0 to 0xFFC read, in ascending address order, 0x80 (0x81 when NCH is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1. Writes to them have no effect.
- R10: Offset 0x100 + 0x20×c + 4×w, with c below NCH and w from 0 to 4, addresses word w of channel c. A write pulses `chan_wr_o[c]` in the request cycle, with `chan_word_o` = w and `chan_wdata_o` = the write data. A read returns `chan_rdata_i[32c+31:32c]` while `chan_word_o` = w. No more than one strobe bit is ever high.
- R11: Any other offset is an error. This covers a channel slot at or above NCH, a word index 5 to 7 inside a slot, the gaps in the global area, and the area between 0x200 and 0xFDF. An error response returns zero, changes no register, raises no strobe, and sets `rsp_err` for that one response.
- R12: Every request cycle yields exactly one response cycle on the following cycle, with `rsp_valid` high. Write responses carry zero data. `rsp_valid` is low when there was no request.
- R13: After synchronous reset, both raw status vectors, the global configuration register and the sync register are zero. `irq_o` and `ctl_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the request; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Request hit no mapped register |
| tc_evt_i | input | NCH | Terminal-count event pulses, one per channel |
| err_evt_i | input | NCH | Error event pulses, one per channel |
| chan_cfg_i | input | 32×NCH | Configuration word of each channel |
| chan_rdata_i | input | 32×NCH | Word of each channel selected by `chan_word_o` |
| chan_wr_o | output | NCH | One-hot write strobe into the channel window |
| chan_word_o | output | 3 | Word index within the channel slot |
| chan_wdata_o | output | 32 | Write data toward the channels |
| ctl_en_o | output | 1 | Controller enable (global configuration bit 0) |
| sync_o | output | SYNC_W | Sync register contents |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sends events and clear writes to the same bit in the same cycle. A design that lets the clear win would lose an interrupt and show a zero raw bit. It changes the configuration enable bits with no event pending. A design that latched the masks, or took them from the wrong bit, would leave the line or the masked views stale. It probes channel slots above the channel count, word indices 5 to 7 and gaps in the global area. A loose decoder would return data, fire a channel strobe or miss the error flag. A long pseudo-random phase mixes events, partial clears and mask changes, and compares the line and every response against a reference model on each cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_TC_STAT,
        SEL_TC_CLR,
        SEL_ERR_STAT,
        SEL_ERR_CLR,
        SEL_TC_RAW,
        SEL_ERR_RAW,
        SEL_EN_MAP,
        SEL_GCFG,
        SEL_SYNC,
        SEL_IDENT,
        SEL_CHAN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic       hit;
        logic [2:0] slot;
        logic [2:0] word;
    } dec_t;

    // word index (byte offset / 4) of the global registers
    localparam logic [3:0] W_STAT     = 4'd0;
    localparam logic [3:0] W_TC_STAT  = 4'd1;
    localparam logic [3:0] W_TC_CLR   = 4'd2;
    localparam logic [3:0] W_ERR_STAT = 4'd3;
    localparam logic [3:0] W_ERR_CLR  = 4'd4;
    localparam logic [3:0] W_TC_RAW   = 4'd5;
    localparam logic [3:0] W_ERR_RAW  = 4'd6;
    localparam logic [3:0] W_EN_MAP   = 4'd7;
    localparam logic [3:0] W_GCFG     = 4'd12;
    localparam logic [3:0] W_SYNC     = 4'd13;

    localparam int CH_WORDS    = 5;
    localparam int TC_IE_BIT   = 15;
    localparam int ERR_IE_BIT  = 14;
    localparam int CH_EN_BIT   = 0;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx, input int nch);
        logic [7:0] b;
        case (idx)
            3'd0:    b = (nch == 2) ? 8'h81 : 8'h80;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h0A;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [9:0] addr_w,
    output dec_t       dec
);
    logic [2:0] slot;
    logic [2:0] word;

    assign slot = addr_w[5:3];
    assign word = addr_w[2:0];

    always_comb begin
        dec.sel  = SEL_NONE;
        dec.hit  = 1'b0;
        dec.slot = slot;
        dec.word = word;
        if (addr_w[9:6] == 4'h1) begin
            dec.sel = SEL_CHAN;
            dec.hit = (int'(slot) < NCH) && (int'(word) < CH_WORDS);
        end else if (addr_w[9:3] == 7'h7F) begin
            dec.sel = SEL_IDENT;
            dec.hit = 1'b1;
        end else if (addr_w[9:4] == 6'd0) begin
            dec.hit = 1'b1;
            case (addr_w[3:0])
                W_STAT:     dec.sel = SEL_STAT;
                W_TC_STAT:  dec.sel = SEL_TC_STAT;
                W_TC_CLR:   dec.sel = SEL_TC_CLR;
                W_ERR_STAT: dec.sel = SEL_ERR_STAT;
                W_ERR_CLR:  dec.sel = SEL_ERR_CLR;
                W_TC_RAW:   dec.sel = SEL_TC_RAW;
                W_ERR_RAW:  dec.sel = SEL_ERR_RAW;
                W_EN_MAP:   dec.sel = SEL_EN_MAP;
                W_GCFG:     dec.sel = SEL_GCFG;
                W_SYNC:     dec.sel = SEL_SYNC;
                default: begin
                    dec.sel = SEL_NONE;
                    dec.hit = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_irq_evt_bank.sv
module dma_irq_evt_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] evt,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_bits,
    output logic [NCH-1:0] raw
);
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    raw[c] <= 1'b0;
                end else if (evt[c]) begin
                    raw[c] <= 1'b1;           // event beats a same-cycle clear
                end else if (clr_we && clr_bits[c]) begin
                    raw[c] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SYNC_W = 16
) (
    input  dec_t              dec,
    input  logic              is_write,
    input  logic [NCH-1:0]    tc_raw,
    input  logic [NCH-1:0]    err_raw,
    input  logic [NCH-1:0]    tc_mask,
    input  logic [NCH-1:0]    err_mask,
    input  logic [NCH-1:0]    en_map,
    input  logic              gcfg_en,
    input  logic [SYNC_W-1:0] sync_q,
    input  logic [NCH*32-1:0] chan_rdata,
    output logic [31:0]       rdata,
    output logic              err
);
    logic [NCH-1:0] tc_m;
    logic [NCH-1:0] err_m;
    logic [31:0]    chan_word;

    assign tc_m  = tc_raw & tc_mask;
    assign err_m = err_raw & err_mask;

    always_comb begin
        chan_word = 32'd0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(dec.slot) == c) chan_word = chan_rdata[c*32 +: 32];
        end
    end

    always_comb begin
        rdata = 32'd0;
        err   = !dec.hit;
        if (dec.hit && !is_write) begin
            case (dec.sel)
                SEL_STAT:     rdata = 32'(tc_m | err_m);
                SEL_TC_STAT:  rdata = 32'(tc_m);
                SEL_ERR_STAT: rdata = 32'(err_m);
                SEL_TC_RAW:   rdata = 32'(tc_raw);
                SEL_ERR_RAW:  rdata = 32'(err_raw);
                SEL_EN_MAP:   rdata = 32'(en_map);
                SEL_GCFG:     rdata = {31'd0, gcfg_en};
                SEL_SYNC:     rdata = 32'(sync_q);
                SEL_IDENT:    rdata = {24'd0, ident_byte(dec.word, NCH)};
                SEL_CHAN:     rdata = chan_word;
                default:      rdata = 32'd0;
            endcase
        end
    end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SYNC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NCH-1:0]    tc_evt_i,
    input  logic [NCH-1:0]    err_evt_i,
    input  logic [NCH*32-1:0] chan_cfg_i,
    input  logic [NCH*32-1:0] chan_rdata_i,
    output logic [NCH-1:0]    chan_wr_o,
    output logic [2:0]        chan_word_o,
    output logic [31:0]       chan_wdata_o,
    output logic              ctl_en_o,
    output logic [SYNC_W-1:0] sync_o,
    output logic              irq_o
);
    dec_t              dec;
    logic              wr_ok;
    logic [NCH-1:0]    tc_raw;
    logic [NCH-1:0]    err_raw;
    logic [NCH-1:0]    tc_mask;
    logic [NCH-1:0]    err_mask;
    logic [NCH-1:0]    en_map;
    logic              gcfg_en;
    logic [SYNC_W-1:0] sync_q;
    logic [31:0]       rd_data;
    logic              rd_err;
    logic              unused_bits;

    dma_irq_decode #(.NCH(NCH)) u_dec (
        .addr_w (req_addr[11:2]),
        .dec    (dec)
    );

    assign wr_ok = req_valid && req_write && dec.hit;

    // per-channel enables taken from the configuration words
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_cfg
            assign tc_mask[c]  = chan_cfg_i[c*32 + TC_IE_BIT];
            assign err_mask[c] = chan_cfg_i[c*32 + ERR_IE_BIT];
            assign en_map[c]   = chan_cfg_i[c*32 + CH_EN_BIT];
            assign chan_wr_o[c] = wr_ok && (dec.sel == SEL_CHAN) && (int'(dec.slot) == c);
        end
    endgenerate

    assign chan_word_o  = dec.word;
    assign chan_wdata_o = req_wdata;
    assign unused_bits  = ^{chan_cfg_i, req_addr[1:0]};

    dma_irq_evt_bank #(.NCH(NCH)) u_tc_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (tc_evt_i),
        .clr_we   (wr_ok && dec.sel == SEL_TC_CLR),
        .clr_bits (req_wdata[NCH-1:0]),
        .raw      (tc_raw)
    );

    dma_irq_evt_bank #(.NCH(NCH)) u_err_bank (
        .clk      (clk),
        .rst      (rst),
        .evt      (err_evt_i),
        .clr_we   (wr_ok && dec.sel == SEL_ERR_CLR),
        .clr_bits (req_wdata[NCH-1:0]),
        .raw      (err_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_en <= 1'b0;
            sync_q  <= '0;
        end else if (wr_ok) begin
            if (dec.sel == SEL_GCFG) gcfg_en <= req_wdata[0];
            if (dec.sel == SEL_SYNC) sync_q  <= req_wdata[SYNC_W-1:0];
        end
    end

    dma_irq_rdmux #(.NCH(NCH), .SYNC_W(SYNC_W)) u_rd (
        .dec        (dec),
        .is_write   (req_write),
        .tc_raw     (tc_raw),
        .err_raw    (err_raw),
        .tc_mask    (tc_mask),
        .err_mask   (err_mask),
        .en_map     (en_map),
        .gcfg_en    (gcfg_en),
        .sync_q     (sync_q),
        .chan_rdata (chan_rdata_i),
        .rdata      (rd_data),
        .err        (rd_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= 32'd0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rd_data : 32'd0;
            rsp_err   <= req_valid && rd_err;
        end
    end

    assign ctl_en_o = gcfg_en;
    assign sync_o   = sync_q;
    assign irq_o    = |((tc_raw & tc_mask) | (err_raw & err_mask));

endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           req_valid,
    input logic           req_write,
    input logic [11:0]    req_addr,
    input logic [31:0]    req_wdata,
    input logic [NCH-1:0] tc_evt_i,
    input logic [NCH-1:0] err_evt_i,
    input logic [NCH-1:0] tc_raw,
    input logic [NCH-1:0] err_raw,
    input logic           rsp_valid,
    input logic [31:0]    rsp_rdata,
    input logic           rsp_err,
    input logic           irq_o,
    input logic [NCH-1:0] chan_wr_o
);
    p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
        tc_evt_i != '0 |=> (tc_raw & $past(tc_evt_i)) == $past(tc_evt_i));

    p_evt_wins_clear_r5: assert property (@(posedge clk) disable iff (rst)
        err_evt_i != '0 |=> (err_raw & $past(err_evt_i)) == $past(err_evt_i));

    p_clear_tc_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[11:2] == 10'h002 && tc_evt_i == '0)
        |=> (tc_raw & $past(req_wdata[NCH-1:0])) == '0);

    p_raw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_write) && tc_evt_i == '0 && err_evt_i == '0)
        |=> ($stable(tc_raw) && $stable(err_raw)));

    p_irq_needs_raw_r2: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (tc_raw | err_raw) != '0);

    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_rsp_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

    p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_wr_o));
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .tc_evt_i  (tc_evt_i),
    .err_evt_i (err_evt_i),
    .tc_raw    (tc_raw),
    .err_raw   (err_raw),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .irq_o     (irq_o),
    .chan_wr_o (chan_wr_o)
);

// File: tb/tb_dma_irq_regs.sv
module tb_dma_irq_regs;
    localparam int NCH    = 8;
    localparam int SYNC_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic [NCH-1:0]    tc_evt = '0;
    logic [NCH-1:0]    err_evt = '0;
    logic [NCH*32-1:0] cfg = '0;
    logic [NCH*32-1:0] chan_rdata;
    logic [NCH-1:0]    chan_wr;
    logic [2:0]        chan_word;
    logic [31:0]       chan_wdata;
    logic              ctl_en;
    logic [SYNC_W-1:0] sync_v;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign chan_rdata[c*32 +: 32] = {8'hC5, 8'(c), 13'd0, chan_word};
    end

    dma_irq_regs #(.NCH(NCH), .SYNC_W(SYNC_W)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .tc_evt_i(tc_evt), .err_evt_i(err_evt),
        .chan_cfg_i(cfg), .chan_rdata_i(chan_rdata), .chan_wr_o(chan_wr),
        .chan_word_o(chan_word), .chan_wdata_o(chan_wdata), .ctl_en_o(ctl_en),
        .sync_o(sync_v), .irq_o(irq)
    );

    // ---------------- reference model ----------------
    logic [NCH-1:0]    m_tc, m_err;
    logic              m_gen;
    logic [SYNC_W-1:0] m_sync;
    logic              e_valid, e_err;
    logic [31:0]       e_data;

    function automatic logic [NCH-1:0] mask_of(input int bitpos);
        logic [NCH-1:0] m;
        for (int c = 0; c < NCH; c++) m[c] = cfg[c*32 + bitpos];
        return m;
    endfunction

    function automatic logic [7:0] id_val(input int i);
        case (i)
            0: return (NCH == 2) ? 8'h81 : 8'h80;
            1: return 8'h10;  2: return 8'h04;  3: return 8'h0A;
            4: return 8'h0D;  5: return 8'hF0;  6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

    // returns {error, data} for an access, from model state
    function automatic logic [32:0] access(input logic wr, input logic [11:0] a);
        int slot, w;
        logic [NCH-1:0] tm, em;
        tm = m_tc & mask_of(15);
        em = m_err & mask_of(14);
        if (a >= 12'h100 && a < 12'h200) begin
            slot = int'(a[7:5]); w = int'(a[4:2]);
            if (slot < NCH && w < 5)
                return {1'b0, wr ? 32'd0 : {8'hC5, 8'(slot), 13'd0, 3'(w)}};
            return {1'b1, 32'd0};
        end
        if (a >= 12'hFE0) return {1'b0, wr ? 32'd0 : {24'd0, id_val(int'(a[4:2]))}};
        if (a >= 12'h040) return {1'b1, 32'd0};
        case (a[5:2])
            4'd0:  return {1'b0, wr ? 32'd0 : 32'(tm | em)};
            4'd1:  return {1'b0, wr ? 32'd0 : 32'(tm)};
            4'd2:  return {1'b0, 32'd0};
            4'd3:  return {1'b0, wr ? 32'd0 : 32'(em)};
            4'd4:  return {1'b0, 32'd0};
            4'd5:  return {1'b0, wr ? 32'd0 : 32'(m_tc)};
            4'd6:  return {1'b0, wr ? 32'd0 : 32'(m_err)};
            4'd7:  return {1'b0, wr ? 32'd0 : 32'(mask_of(0))};
            4'd12: return {1'b0, wr ? 32'd0 : {31'd0, m_gen}};
            4'd13: return {1'b0, wr ? 32'd0 : 32'(m_sync)};
            default: return {1'b1, 32'd0};
        endcase
    endfunction

    always @(posedge clk) begin
        logic [32:0] r;
        logic [NCH-1:0] ctc, cer;
        if (rst) begin
            m_tc = '0; m_err = '0; m_gen = 0; m_sync = '0;
            e_valid = 0; e_err = 0; e_data = '0;
        end else begin
            r = req_valid ? access(req_write, req_addr) : 33'd0;
            e_valid = req_valid; e_err = r[32]; e_data = r[31:0];
            ctc = '0; cer = '0;
            if (req_valid && req_write) begin
                if (req_addr[11:2] == 10'h002) ctc = req_wdata[NCH-1:0];
                if (req_addr[11:2] == 10'h004) cer = req_wdata[NCH-1:0];
                if (req_addr[11:2] == 10'h00C) m_gen = req_wdata[0];
                if (req_addr[11:2] == 10'h00D) m_sync = req_wdata[SYNC_W-1:0];
            end
            m_tc  = tc_evt  | (m_tc  & ~ctc);
            m_err = err_evt | (m_err & ~cer);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 irq", 32'(irq),
                  32'(|((m_tc & mask_of(15)) | (m_err & mask_of(14)))));
            check("R8 ctl_en", 32'(ctl_en), 32'(m_gen));
            check("R8 sync", 32'(sync_v), 32'(m_sync));
            check("R12 rsp_valid", 32'(rsp_valid), 32'(e_valid));
            if (e_valid) begin
                check("R6/R9/R10 rsp_rdata", rsp_rdata, e_data);
                check("R11 rsp_err", 32'(rsp_err), 32'(e_err));
            end
        end
    end

    task automatic cyc(input logic v, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic [NCH-1:0] te,
                       input logic [NCH-1:0] ee);
        logic [NCH-1:0] exp_stb;
        @(negedge clk); #1;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        tc_evt = te; err_evt = ee;
        #1;
        exp_stb = '0;
        if (v && w && a >= 12'h100 && a < 12'h200 && int'(a[7:5]) < NCH && int'(a[4:2]) < 5)
            exp_stb[a[7:5]] = 1'b1;
        check("R10 R11 chan_wr strobe", 32'(chan_wr), 32'(exp_stb));
        if (exp_stb != '0) begin
            check("R10 chan_word", 32'(chan_word), 32'(a[4:2]));
            check("R10 chan_wdata", chan_wdata, d);
        end
    endtask

    task automatic rd(input logic [11:0] a);   cyc(1, 0, a, 32'd0, '0, '0); endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, 1, a, d, '0, '0); endtask
    task automatic idle();                     cyc(0, 0, '0, '0, '0, '0); endtask

    task automatic set_cfg(input int c, input logic [31:0] v);
        @(negedge clk); #1;
        cfg[c*32 +: 32] = v;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst = 0;
        @(negedge clk);
        // R13 reset state
        check("R13 irq after reset", 32'(irq), 0);
        check("R13 ctl_en after reset", 32'(ctl_en), 0);
        check("R13 sync after reset", 32'(sync_v), 0);
        rd(12'h014); rd(12'h018); rd(12'h030); rd(12'h034); idle();

        // R1 masks from cfg bits 15/14, R7 enable bitmap from bit 0
        set_cfg(0, 32'h0000_8001);
        set_cfg(1, 32'h0000_4000);
        set_cfg(2, 32'h0000_C001);
        set_cfg(3, 32'h0000_0001);
        idle();
        rd(12'h01C);
        // R3 events on masked ch0 and unmasked ch3
        cyc(0, 0, '0, '0, 8'b0000_1001, '0);
        idle();
        check("R3 R2 irq after tc event", 32'(irq), 1);
        rd(12'h000); rd(12'h004); rd(12'h014); rd(12'h00C);
        // R4 clear only ch0; ch3 raw stays
        wr(12'h008, 32'h0000_0001);
        idle();
        check("R4 irq after clear", 32'(irq), 0);
        rd(12'h014); rd(12'h008);
        // R1 unmasking ch3 raises irq without an event
        set_cfg(3, 32'h0000_8001);
        idle();
        check("R1 irq follows cfg enable", 32'(irq), 1);
        set_cfg(3, 32'h0000_0001);
        idle();
        // R5 error event and clear on the same bit, same cycle
        cyc(0, 0, '0, '0, '0, 8'b0000_0010);
        cyc(1, 1, 12'h010, 32'h0000_0002, '0, 8'b0000_0010);
        idle();
        check("R5 irq stays after racing clear", 32'(irq), 1);
        rd(12'h018); rd(12'h000);
        wr(12'h010, 32'hFFFF_FFFF); rd(12'h018);
        // R8 global config and sync
        wr(12'h030, 32'hFFFF_FFFF); rd(12'h030);
        wr(12'h034, 32'h1234_BEEF); rd(12'h034);
        wr(12'h030, 32'h0000_0000); rd(12'h030);
        // R9 identification words, write ignored
        for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i));
        wr(12'hFE0, 32'h0000_00FF); rd(12'hFE0);
        // R10 channel window
        wr(12'h170, 32'hA5A5_0001);
        wr(12'h100, 32'h0000_1111);
        rd(12'h1A4); rd(12'h1E0); rd(12'h110);
        // R11 errors: bad word index, gap, far area, write to gap
        rd(12'h114); rd(12'h11C); rd(12'h020); rd(12'h038); rd(12'h200);
        rd(12'h800); wr(12'h040, 32'hFFFF_FFFF); wr(12'h118, 32'h1);
        wr(12'h02C, 32'h1);
        rd(12'h030); rd(12'h034);
        idle(); idle();
        // pseudo-random mix
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 37 == 5) set_cfg(n % NCH, {16'd0, lfsr[15:14], 13'd0, lfsr[0]});
            case (lfsr[2:0])
                3'd0, 3'd1: cyc(1, 1, 12'h008, {24'd0, lfsr[15:8]}, lfsr[7:0] & lfsr[15:8], '0);
                3'd2:       cyc(1, 1, 12'h010, {24'd0, lfsr[11:4]}, '0, lfsr[7:0]);
                3'd3:       cyc(1, 0, 12'h000, '0, lfsr[10:3] & 8'h55, '0);
                3'd4:       cyc(1, 0, 12'h014, '0, '0, lfsr[12:5] & 8'hA2);
                3'd5:       cyc(1, 0, 12'h018, '0, '0, '0);
                default:    cyc(0, 0, '0, '0, lfsr[8:1] & 8'h11, lfsr[13:6] & 8'h0C);
            endcase
        end
        idle(); idle();
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule